// File: doc/BRIEF.md
# Control Pipe Packet Buffer

This block holds the data of one control-transfer stage for a USB host. One 256-byte storage area serves both directions. Software reaches it through a single byte-wide FIFO port. A direction input decides the role of that port. In transmit, software pushes bytes and the packet engine drains them. In receive, the packet engine fills the buffer and software pops the bytes.

A receive stage completes in one of two ways. Either a packet arrives that is shorter than the selected maximum packet size, or the storage fills up. At that point a sticky ready flag is set, the buffer locks against further input, and the accumulated byte count is shown on a length output. In transmit, software commits the bytes it has written. The engine then reads them out and signals the end of the packet, which raises a sticky empty flag.

Both flags are cleared by writing 1 to them, and each has its own enable for a shared interrupt. A clear command discards the contents, the count and any pending state.

Top module: `ctl_pipe_buf`

## Requirements
- R1: The storage holds 256 bytes. Bytes are read back in the order in which they were written, and the read and write pointers wrap within the 256 bytes.
- R2: When `dir_tx_i`=1, software writes bytes and the engine reads them. When `dir_tx_i`=0, the engine writes bytes and software reads them. A software write while `dir_tx_i`=0 is ignored.
- R3: `mps_sel_i` selects the maximum packet size: 0 gives 8 bytes, 1 gives 16, 2 gives 32 and 3 gives 64. A received packet with fewer bytes than this size sets ready (`sts_o[0]`) when its end-of-packet strobe arrives.
- R4: A received packet of exactly the maximum size does not set ready. Further packets keep accumulating after it.
- R5: The 256th stored byte sets ready even before its end-of-packet strobe. The count saturates at 256.
- R6: `rx_len_o` shows the number of bytes received. A zero-length packet sets ready and leaves the count at 0.
- R7: A software read at or beyond the received count returns 0 and does not advance the read pointer.
- R8: `clr_i` empties the buffer, zeroes the count and pointers, and drops the receive lock and any pending transmit. It takes priority over a byte write in the same cycle.
- R9: After `tx_commit_i`, `usb_tx_avail_o` stays high while unsent bytes remain. `usb_tx_done_i` sets empty (`sts_o[1]`) and zeroes the count.
- R10: The status bits are sticky. A 1 on `sts_clr_i` clears the matching bit, and a set in the same cycle wins over the clear. `irq_o` is the OR of the status bits masked by `irq_en_i`.
- R11: Once ready is set in receive, further received bytes and end-of-packet strobes are ignored until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_tx_i | input | 1 | 1 = transmit, 0 = receive |
| mps_sel_i | input | 2 | Maximum packet size select |
| clr_i | input | 1 | Discard buffer contents |
| sw_wr_i | input | 1 | Software byte write strobe |
| sw_wdata_i | input | 8 | Software write byte |
| sw_rd_i | input | 1 | Software byte read strobe |
| sw_rdata_o | output | 8 | Byte at software read pointer, 0 when none |
| tx_commit_i | input | 1 | Hand written bytes to the engine |
| usb_rx_valid_i | input | 1 | Received byte strobe |
| usb_rx_data_i | input | 8 | Received byte |
| usb_rx_eop_i | input | 1 | End of received packet |
| usb_tx_rd_i | input | 1 | Engine pops one byte |
| usb_tx_data_o | output | 8 | Byte for the engine |
| usb_tx_avail_o | output | 1 | Unsent bytes remain |
| usb_tx_done_i | input | 1 | Transmit packet finished |
| rx_len_o | output | 9 | Received or written byte count |
| sts_o | output | 2 | Bit 0 ready, bit 1 empty |
| sts_clr_i | input | 2 | Write-1-to-clear for `sts_o` |
| irq_en_i | input | 2 | Interrupt enables per status bit |
| irq_o | output | 1 | Interrupt request |

## Verification
A pointer or count that drifts shows up at the ports in two ways. The next software read returns the wrong byte, or returns 0 early. The length output also reports a count that does not match the bytes sent, and this is visible in the same cycle after the offending edge.

A wrong short-packet decision or receive lock shows up as a ready flag that is set or missing. That is visible one cycle after the end-of-packet strobe, or as a count that still grows after the lock. A clear that does not reach all state shows up as stale data or a raised transmit-available flag right after the clear.

// File: rtl/ctl_pipe_pkg.sv
package ctl_pipe_pkg;
  localparam int unsigned STS_W = 2;
  localparam int unsigned STS_RDY = 0;
  localparam int unsigned STS_EMP = 1;

  // 0..3 -> 8,16,32,64 bytes
  function automatic logic [6:0] mps_bytes(input logic [1:0] sel);
    return 7'd8 << sel;
  endfunction
endpackage

// File: rtl/ctl_pipe_mem.sv
module ctl_pipe_mem #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ctl_pipe_ctrl.sv
module ctl_pipe_ctrl
  import ctl_pipe_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_tx_i,
  input  logic [1:0]    mps_sel_i,
  input  logic          clr_i,
  input  logic          sw_wr_i,
  input  logic [DW-1:0] sw_wdata_i,
  input  logic          sw_rd_i,
  input  logic          tx_commit_i,
  input  logic          usb_rx_valid_i,
  input  logic [DW-1:0] usb_rx_data_i,
  input  logic          usb_rx_eop_i,
  input  logic          usb_tx_rd_i,
  input  logic          usb_tx_done_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [AW-1:0] mem_raddr_o,
  output logic [DW-1:0] sw_rdata_o,
  output logic [DW-1:0] usb_tx_data_o,
  output logic          usb_tx_avail_o,
  output logic [LW-1:0] len_o,
  output logic          rdy_set_o,
  output logic          emp_set_o
);
  localparam logic [LW-1:0] FULL_LEN = LW'(DEPTH);
  localparam logic [LW-1:0] LAST_LEN = LW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] len_q, rd_cnt_q, pkt_cnt_q, mps;
  logic          rx_done_q, tx_pend_q;
  logic          full, avail, rx_wr, tx_wr, rd_step, rx_eop, short_pkt, fill_done, tx_fin;

  assign mps       = LW'(mps_bytes(mps_sel_i));
  assign full      = (len_q == FULL_LEN);
  assign avail     = (rd_cnt_q < len_q);
  assign rx_wr     = !dir_tx_i && usb_rx_valid_i && !rx_done_q && !full;
  assign tx_wr     = dir_tx_i && sw_wr_i && !tx_pend_q && !full;
  assign rd_step   = dir_tx_i ? (usb_tx_rd_i && tx_pend_q && avail) : (sw_rd_i && avail);
  assign rx_eop    = !dir_tx_i && usb_rx_eop_i && !rx_done_q;
  assign short_pkt = rx_eop && (pkt_cnt_q < mps);
  assign fill_done = rx_wr && (len_q == LAST_LEN);
  assign tx_fin    = dir_tx_i && tx_pend_q && usb_tx_done_i;

  assign mem_we_o    = (rx_wr || tx_wr) && !clr_i;
  assign mem_waddr_o = wr_ptr_q;
  assign mem_wdata_o = dir_tx_i ? sw_wdata_i : usb_rx_data_i;
  assign mem_raddr_o = rd_ptr_q;

  assign sw_rdata_o     = (!dir_tx_i && avail) ? mem_rdata_i : '0;
  assign usb_tx_avail_o = dir_tx_i && tx_pend_q && avail;
  assign usb_tx_data_o  = usb_tx_avail_o ? mem_rdata_i : '0;
  assign len_o          = len_q;
  assign rdy_set_o      = (short_pkt || fill_done) && !clr_i;
  assign emp_set_o      = tx_fin && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      len_q     <= '0;
      rd_cnt_q  <= '0;
      pkt_cnt_q <= '0;
      rx_done_q <= 1'b0;
      tx_pend_q <= 1'b0;
    end else if (clr_i || tx_fin) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      len_q     <= '0;
      rd_cnt_q  <= '0;
      pkt_cnt_q <= '0;
      rx_done_q <= 1'b0;
      tx_pend_q <= 1'b0;
    end else begin
      if (rx_wr || tx_wr) begin
        wr_ptr_q <= wr_ptr_q + 1'b1;
        len_q    <= len_q + 1'b1;
      end
      if (rx_wr) pkt_cnt_q <= pkt_cnt_q + 1'b1;
      if (rx_eop) pkt_cnt_q <= '0;
      if (rd_step) begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
        rd_cnt_q <= rd_cnt_q + 1'b1;
      end
      if (short_pkt || fill_done) rx_done_q <= 1'b1;
      if (dir_tx_i && tx_commit_i) tx_pend_q <= 1'b1;
    end
  end

  // R5
  len_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) len_q <= FULL_LEN);
  // R7
  rd_behind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) rd_cnt_q <= len_q);
  // R8
  clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (len_q == '0 && rd_cnt_q == '0 && !rx_done_q && !tx_pend_q));
  // R3
  lock_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_q) |-> ($past(usb_rx_eop_i) || len_q == FULL_LEN));
  // R11
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_q && !clr_i && !dir_tx_i) |=> $stable(len_q));
  // R9
  tx_done_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fin |=> (len_q == '0 && !usb_tx_avail_o));
endmodule

// File: rtl/ctl_pipe_evt.sv
module ctl_pipe_evt
  import ctl_pipe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] set_i,
  input  logic [STS_W-1:0] clr_i,
  input  logic [STS_W-1:0] en_i,
  output logic [STS_W-1:0] sts_o,
  output logic             irq_o
);
  logic [STS_W-1:0] sts_q;

  for (genvar g = 0; g < STS_W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_q[g] <= 1'b0;
      else if (set_i[g]) sts_q[g] <= 1'b1;
      else if (clr_i[g]) sts_q[g] <= 1'b0;
    end

    // R10
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_q[g] && !clr_i[g]) |=> sts_q[g]);
    // R10
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> sts_q[g]);
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & en_i);
endmodule

// File: rtl/ctl_pipe_buf.sv
module ctl_pipe_buf
  import ctl_pipe_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_tx_i,
  input  logic [1:0]       mps_sel_i,
  input  logic             clr_i,
  input  logic             sw_wr_i,
  input  logic [DW-1:0]    sw_wdata_i,
  input  logic             sw_rd_i,
  output logic [DW-1:0]    sw_rdata_o,
  input  logic             tx_commit_i,
  input  logic             usb_rx_valid_i,
  input  logic [DW-1:0]    usb_rx_data_i,
  input  logic             usb_rx_eop_i,
  input  logic             usb_tx_rd_i,
  output logic [DW-1:0]    usb_tx_data_o,
  output logic             usb_tx_avail_o,
  input  logic             usb_tx_done_i,
  output logic [LW-1:0]    rx_len_o,
  output logic [STS_W-1:0] sts_o,
  input  logic [STS_W-1:0] sts_clr_i,
  input  logic [STS_W-1:0] irq_en_i,
  output logic             irq_o
);
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          rdy_set, emp_set;

  ctl_pipe_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  ctl_pipe_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .dir_tx_i       (dir_tx_i),
    .mps_sel_i      (mps_sel_i),
    .clr_i          (clr_i),
    .sw_wr_i        (sw_wr_i),
    .sw_wdata_i     (sw_wdata_i),
    .sw_rd_i        (sw_rd_i),
    .tx_commit_i    (tx_commit_i),
    .usb_rx_valid_i (usb_rx_valid_i),
    .usb_rx_data_i  (usb_rx_data_i),
    .usb_rx_eop_i   (usb_rx_eop_i),
    .usb_tx_rd_i    (usb_tx_rd_i),
    .usb_tx_done_i  (usb_tx_done_i),
    .mem_rdata_i    (mem_rdata),
    .mem_we_o       (mem_we),
    .mem_waddr_o    (mem_waddr),
    .mem_wdata_o    (mem_wdata),
    .mem_raddr_o    (mem_raddr),
    .sw_rdata_o     (sw_rdata_o),
    .usb_tx_data_o  (usb_tx_data_o),
    .usb_tx_avail_o (usb_tx_avail_o),
    .len_o          (rx_len_o),
    .rdy_set_o      (rdy_set),
    .emp_set_o      (emp_set)
  );

  ctl_pipe_evt u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({emp_set, rdy_set}),
    .clr_i  (sts_clr_i),
    .en_i   (irq_en_i),
    .sts_o  (sts_o),
    .irq_o  (irq_o)
  );
endmodule

// File: tb/ctl_pipe_buf_bench.sv
`timescale 1ns/1ps
module ctl_pipe_buf_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_tx = 1'b0;
  logic [1:0] mps_sel = 2'd0;
  logic       clr = 1'b0;
  logic       sw_wr = 1'b0;
  logic [7:0] sw_wdata = 8'h00;
  logic       sw_rd = 1'b0;
  logic [7:0] sw_rdata;
  logic       tx_commit = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_eop = 1'b0;
  logic       tx_rd = 1'b0;
  logic [7:0] tx_data;
  logic       tx_avail;
  logic       tx_done = 1'b0;
  logic [8:0] len;
  logic [1:0] sts;
  logic [1:0] sts_clr = 2'b00;
  logic [1:0] irq_en = 2'b00;
  logic       irq;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ctl_pipe_buf u_ctl_pipe_buf (
    .clk_i(clk), .rst_ni(rst_n), .dir_tx_i(dir_tx), .mps_sel_i(mps_sel), .clr_i(clr),
    .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata), .sw_rd_i(sw_rd), .sw_rdata_o(sw_rdata),
    .tx_commit_i(tx_commit), .usb_rx_valid_i(rx_valid), .usb_rx_data_i(rx_data),
    .usb_rx_eop_i(rx_eop), .usb_tx_rd_i(tx_rd), .usb_tx_data_o(tx_data),
    .usb_tx_avail_o(tx_avail), .usb_tx_done_i(tx_done), .rx_len_o(len), .sts_o(sts),
    .sts_clr_i(sts_clr), .irq_en_i(irq_en), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rx_pkt(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = base + 8'(i);
    end
    @(negedge clk); rx_valid = 1'b0; rx_eop = 1'b1;
    @(negedge clk); rx_eop = 1'b0;
  endtask

  task automatic sw_pop(input string req, input logic [7:0] exp);
    chk(req, sw_rdata, exp);
    sw_rd = 1'b1;
    @(negedge clk); sw_rd = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1; sts_clr = 2'b11;
    @(negedge clk); clr = 1'b0; sts_clr = 2'b00;
  endtask

  task automatic t_reset();
    chk("R10 sts reset", sts, 0);
    chk("R10 irq reset", irq, 0);
    chk("R6 len reset", len, 0);
    chk("R7 rdata reset", sw_rdata, 0);
    chk("R9 avail reset", tx_avail, 0);
  endtask

  task automatic t_short();
    dir_tx = 1'b0; mps_sel = 2'd0; irq_en = 2'b01;
    rx_pkt(5, 8'h10);
    chk("R3 short sets ready", sts[0], 1);
    chk("R6 length", len, 5);
    chk("R10 irq enabled", irq, 1);
    rx_pkt(4, 8'h80);
    chk("R11 locked len", len, 5);
    chk("R11 still ready", sts[0], 1);
    @(negedge clk); sw_wr = 1'b1; sw_wdata = 8'hAA;
    @(negedge clk); sw_wr = 1'b0;
    chk("R2 sw write ignored in rx", len, 5);
    for (int i = 0; i < 5; i++) sw_pop("R2 rx data", 8'h10 + 8'(i));
    sw_pop("R7 past end zero", 8'h00);
    chk("R7 no advance", sw_rdata, 0);
    chk("R7 len kept", len, 5);
  endtask

  task automatic t_fullsize();
    do_clr();
    mps_sel = 2'd1;
    rx_pkt(16, 8'h20);
    chk("R4 max-size no ready", sts[0], 0);
    chk("R4 len 16", len, 16);
    rx_pkt(3, 8'h40);
    chk("R4 then short ready", sts[0], 1);
    chk("R6 len 19", len, 19);
    for (int i = 0; i < 16; i++) sw_pop("R4 data pkt1", 8'h20 + 8'(i));
    for (int i = 0; i < 3; i++) sw_pop("R4 data pkt2", 8'h40 + 8'(i));
  endtask

  task automatic t_mps32();
    do_clr();
    mps_sel = 2'd2;
    rx_pkt(32, 8'h00);
    chk("R3 32 not short", sts[0], 0);
    do_clr();
    rx_pkt(31, 8'h00);
    chk("R3 31 short", sts[0], 1);
  endtask

  task automatic t_zlp();
    do_clr();
    rx_pkt(0, 8'h00);
    chk("R6 zlp ready", sts[0], 1);
    chk("R6 zlp len", len, 0);
    chk("R7 zlp rdata", sw_rdata, 0);
  endtask

  task automatic t_full();
    do_clr();
    mps_sel = 2'd3;
    for (int p = 0; p < 3; p++) rx_pkt(64, 8'(p * 64));
    chk("R4 64 not short", sts[0], 0);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'(192 + i);
    end
    @(negedge clk); rx_valid = 1'b0;
    chk("R5 full ready before eop", sts[0], 1);
    chk("R5 len 256", len, 256);
    rx_pkt(3, 8'hEE);
    chk("R5 saturate", len, 256);
    for (int i = 0; i < 256; i++) sw_pop("R1 order wrap", 8'(i));
    chk("R7 after 256", sw_rdata, 0);
  endtask

  task automatic t_tx();
    do_clr();
    dir_tx = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); sw_wr = 1'b1; sw_wdata = 8'h50 + 8'(i);
    end
    @(negedge clk); sw_wr = 1'b0;
    chk("R9 no avail before commit", tx_avail, 0);
    chk("R9 len written", len, 10);
    @(negedge clk); tx_commit = 1'b1;
    @(negedge clk); tx_commit = 1'b0;
    chk("R9 avail", tx_avail, 1);
    for (int i = 0; i < 10; i++) begin
      chk("R2 tx data", tx_data, 8'h50 + 8'(i));
      tx_rd = 1'b1;
      @(negedge clk); tx_rd = 1'b0;
    end
    chk("R9 drained", tx_avail, 0);
    chk("R9 empty not yet", sts[1], 0);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    chk("R9 empty set", sts[1], 1);
    chk("R9 len zero", len, 0);
    irq_en = 2'b01;
    #1 chk("R10 masked irq", irq, 0);
    irq_en = 2'b10;
    #1 chk("R10 enabled irq", irq, 1);
  endtask

  task automatic t_w1c();
    @(negedge clk); sts_clr = 2'b10;
    @(negedge clk); sts_clr = 2'b00;
    chk("R10 w1c", sts[1], 0);
    tx_commit = 1'b1;
    @(negedge clk); tx_commit = 1'b0; tx_done = 1'b1; sts_clr = 2'b10;
    @(negedge clk); tx_done = 1'b0; sts_clr = 2'b00;
    chk("R10 set wins", sts[1], 1);
  endtask

  task automatic t_clr_prio();
    dir_tx = 1'b0;
    do_clr();
    @(negedge clk); clr = 1'b1; rx_valid = 1'b1; rx_data = 8'h77;
    @(negedge clk); clr = 1'b0; rx_valid = 1'b0;
    chk("R8 clr beats write", len, 0);
    dir_tx = 1'b1;
    @(negedge clk); sw_wr = 1'b1; sw_wdata = 8'h11;
    @(negedge clk); sw_wr = 1'b0; tx_commit = 1'b1;
    @(negedge clk); tx_commit = 1'b0;
    chk("R8 pre avail", tx_avail, 1);
    do_clr();
    chk("R8 clr drops pending", tx_avail, 0);
    chk("R8 clr len", len, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_fullsize();
    t_mps32();
    t_zlp();
    t_full();
    t_tx();
    t_w1c();
    t_clr_prio();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule